// File: doc/BRIEF.md
# SDRAM Write Burst Command Sequencer

This block sits on the controller side of a single x16 SDRAM with four banks and turns host requests into command-bus activity. A host asks for a fixed-length write burst, a read burst, an early stop of the running write (by burst-terminate or by precharge), or a precharge. The sequencer registers the matching command, bank and column onto the SDRAM pins, drives write data and byte masks beat by beat, and samples read data a fixed CAS latency after each read command. Rows are assumed open; activation, refresh, initialization and mode programming happen elsewhere.

A write request starts a burst whose first data word goes out in the same clock as the command. A later write, to any bank, cuts the running burst short and begins a new one at once. Each precharged bank is blocked for a programmable recovery interval, and the host sees that through a ready signal that stays low. Requests that would collide with read data still in flight are held off in the same way.

Top module: `sdram_wseq`

## Requirements
- R1: While reset is held, and until the internal synchronizer has released it, the command lines show NOP (`4'b0111`), DQ is not driven, every DQM bit is high, `rd_valid` is low and `req_ready` is low; once reset is released an idle sequencer accepts a write request at once.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` high) appears on `sd_cmd` (CS#,RAS#,CAS#,WE# from bit 3 down) in the following clock, with `req_op` 0 giving WRITE `4'b0100`, 1 READ `4'b0101`, 2 burst-terminate `4'b0110` and 3 PRECHARGE `4'b0010`; WRITE and READ carry the request's bank and column, PRECHARGE carries the bank with a zero address; every other clock shows NOP.
- R3: A write burst puts `BURST_LEN` words on DQ in consecutive clocks to consecutive columns, starting in the WRITE clock; the word of each beat is the `wr_data` value present at the edge that starts that beat. DQ is driven exactly while DQM is all low; in every other clock DQM is all high and DQ is released.
- R4: A WRITE accepted while a burst runs, to any bank, ends the old burst; its own first word is driven in its command clock and it runs a full `BURST_LEN` beats.
- R5: A burst-terminate ends the running write: on its clock DQ is released and DQM is high, so the last word stored is the one of the previous clock.
- R6: A PRECHARGE ends any running write; on its clock DQ is released and DQM is high.
- R7: After a PRECHARGE to a bank, no WRITE, READ or PRECHARGE to that bank appears on the bus until `T_RP` clocks later, and `req_ready` is low for such requests meanwhile; other banks and burst-terminate are not held.
- R8: A READ may follow a WRITE in the next clock; the words driven by the memory `CAS_LAT` clocks after the READ and in the next `BURST_LEN-1` clocks are each reported on `rd_data` with `rd_valid` high one clock after they were on DQ.
- R9: DQ is released in the clock before and during every clock in which read data is on the bus; all requests are held off (ready low) while a read burst is still being issued or its data is still due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 2 | 0 write, 1 read, 2 terminate, 3 precharge |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_ready | output | 1 | Request accepted on this edge when valid |
| wr_data | input | DQ_W | Write word for the beat that starts at this edge |
| sd_cmd | output | 4 | CS#, RAS#, CAS#, WE# |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | COL_W | Column address |
| sd_dq_out | output | DQ_W | DQ output value |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dqm | output | DM_W | Byte masks, high masks |
| sd_dq_in | input | DQ_W | DQ input value |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | DQ_W | Captured read word |

## Verification
The bench runs a memory model on the bus side and compares what lands in it with what the host intended, so a write that is cut short one beat late (a terminate clock with DQM low, a precharge that still stores data, an interrupted burst that keeps its old column count) leaves a wrong word behind. It times the stall after a precharge to the same bank and to another bank, which catches a recovery counter loaded one off or shared across banks. A read issued in the clock after a write checks the CAS-latency capture window, where an off-by-one pipeline returns the neighbouring word, and a write straight after a read checks that the bus is not driven into returning data.

// File: rtl/sdram_wseq_pkg.sv
package sdram_wseq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_TERM  = 2'd2,
    OP_PRE   = 2'd3
  } host_op_e;

  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_BST   = 4'b0110;
  localparam logic [3:0] CMD_PRE   = 4'b0010;

endpackage

// File: rtl/sdram_wseq_trp.sv
// Per-bank precharge recovery counters.
module sdram_wseq_trp #(
  parameter int BANKS = 4,
  parameter int T_RP  = 3,
  localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int CW   = $clog2(T_RP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_fire,
  input  logic [BA_W-1:0] pre_bank,
  input  logic [BA_W-1:0] ask_bank,
  output logic            ask_busy
);

  logic [BANKS-1:0] busy;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_en;

    always_comb begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
      if (pre_fire && (pre_bank == BA_W'(b))) begin
        cnt_d  = CW'(T_RP - 1);
        cnt_en = 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign busy[b] = (cnt_q != '0);
  end

  assign ask_busy = busy[ask_bank];

endmodule

// File: rtl/sdram_wseq_wbeat.sv
// Write beat counter and DQ / DQM drive.
module sdram_wseq_wbeat #(
  parameter int BURST_LEN = 4,
  parameter int DQ_W      = 16,
  localparam int DM_W     = DQ_W / 8,
  localparam int LW       = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic [DQ_W-1:0] wr_data,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [DM_W-1:0] dqm
);

  logic [LW-1:0]   left_q, left_d;
  logic            oe_q, oe_d;
  logic [DQ_W-1:0] dq_q;

  always_comb begin
    left_d = left_q;
    oe_d   = 1'b0;
    if (start) begin
      oe_d   = 1'b1;
      left_d = LW'(BURST_LEN - 1);
    end else if (stop) begin
      left_d = '0;
    end else if (left_q != '0) begin
      oe_d   = 1'b1;
      left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      left_q <= left_d;
      oe_q   <= oe_d;
    end
  end

  // Data path register, loaded only for a driven beat.
  always_ff @(posedge clk) begin
    if (oe_d) begin
      dq_q <= wr_data;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;
  assign dqm    = {DM_W{~oe_q}};

endmodule

// File: rtl/sdram_wseq_rdcap.sv
// Read beat tracking and CAS-latency capture pipeline.
module sdram_wseq_rdcap #(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int DQ_W      = 16,
  localparam int LW       = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic            busy
);

  logic [LW-1:0]      left_q, left_d;
  logic               beat_q, beat_d;
  logic [CAS_LAT-1:0] sh_q, sh_d;
  logic               cap;
  logic               rv_q;
  logic [DQ_W-1:0]    rd_q;

  always_comb begin
    left_d = left_q;
    beat_d = 1'b0;
    if (start) begin
      beat_d = 1'b1;
      left_d = LW'(BURST_LEN - 1);
    end else if (left_q != '0) begin
      beat_d = 1'b1;
      left_d = left_q - LW'(1);
    end
  end

  if (CAS_LAT == 1) begin : g_cl1
    assign sh_d = beat_q;
  end else begin : g_cln
    assign sh_d = {sh_q[CAS_LAT-2:0], beat_q};
  end

  assign cap = sh_q[CAS_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      beat_q <= 1'b0;
      sh_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      left_q <= left_d;
      beat_q <= beat_d;
      sh_q   <= sh_d;
      rv_q   <= cap;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      rd_q <= dq_in;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
  assign busy     = beat_q | (left_q != '0) | (|sh_q);

endmodule

// File: rtl/sdram_wseq.sv
module sdram_wseq
  import sdram_wseq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 3,
  parameter int COL_W     = 8,
  parameter int DQ_W      = 16,
  parameter int BANKS     = 4,
  localparam int BA_W     = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int DM_W     = DQ_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  output logic             req_ready,
  input  logic [DQ_W-1:0]  wr_data,
  output logic [3:0]       sd_cmd,
  output logic [BA_W-1:0]  sd_ba,
  output logic [COL_W-1:0] sd_addr,
  output logic [DQ_W-1:0]  sd_dq_out,
  output logic             sd_dq_oe,
  output logic [DM_W-1:0]  sd_dqm,
  input  logic [DQ_W-1:0]  sd_dq_in,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_i_n = rs_q[1];

  host_op_e op;
  logic     accept;
  logic     go_wr, go_rd, go_term, go_pre;
  logic     bank_busy;
  logic     rd_busy;

  assign op      = host_op_e'(req_op);
  assign accept  = req_valid & req_ready;
  assign go_wr   = accept & (op == OP_WRITE);
  assign go_rd   = accept & (op == OP_READ);
  assign go_term = accept & (op == OP_TERM);
  assign go_pre  = accept & (op == OP_PRE);

  assign req_ready = rst_i_n & ~rd_busy & ((op == OP_TERM) | ~bank_busy);

  // Command bus: next-state and register.
  logic [3:0]       cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [COL_W-1:0] addr_q, addr_d;
  logic             addr_en;

  always_comb begin
    cmd_d   = CMD_NOP;
    ba_d    = ba_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (accept) begin
      unique case (op)
        OP_WRITE: begin
          cmd_d   = CMD_WRITE;
          ba_d    = req_bank;
          addr_d  = req_col;
          addr_en = 1'b1;
        end
        OP_READ: begin
          cmd_d   = CMD_READ;
          ba_d    = req_bank;
          addr_d  = req_col;
          addr_en = 1'b1;
        end
        OP_TERM: begin
          cmd_d   = CMD_BST;
        end
        OP_PRE: begin
          cmd_d   = CMD_PRE;
          ba_d    = req_bank;
          addr_d  = '0;
          addr_en = 1'b1;
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      if (addr_en) begin
        ba_q   <= ba_d;
        addr_q <= addr_d;
      end
    end
  end

  assign sd_cmd  = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

  sdram_wseq_trp #(
    .BANKS (BANKS),
    .T_RP  (T_RP)
  ) u_trp (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pre_fire (go_pre),
    .pre_bank (req_bank),
    .ask_bank (req_bank),
    .ask_busy (bank_busy)
  );

  sdram_wseq_wbeat #(
    .BURST_LEN (BURST_LEN),
    .DQ_W      (DQ_W)
  ) u_wbeat (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (go_wr),
    .stop    (go_rd | go_term | go_pre),
    .wr_data (wr_data),
    .dq_out  (sd_dq_out),
    .dq_oe   (sd_dq_oe),
    .dqm     (sd_dqm)
  );

  sdram_wseq_rdcap #(
    .BURST_LEN (BURST_LEN),
    .CAS_LAT   (CAS_LAT),
    .DQ_W      (DQ_W)
  ) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (go_rd),
    .dq_in    (sd_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .busy     (rd_busy)
  );

endmodule

// File: rtl/sdram_wseq_chk.sv
module sdram_wseq_chk #(
  parameter int T_RP = 3,
  parameter int BA_W = 2,
  parameter int DM_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_op,
  input logic [BA_W-1:0] req_bank,
  input logic [3:0]      sd_cmd,
  input logic [BA_W-1:0] sd_ba,
  input logic            sd_dq_oe,
  input logic [DM_W-1:0] sd_dqm
);

  localparam logic [3:0] K_READ  = 4'b0101;
  localparam logic [3:0] K_WRITE = 4'b0100;
  localparam logic [3:0] K_BST   = 4'b0110;
  localparam logic [3:0] K_PRE   = 4'b0010;

  AST_WRITE_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> (sd_cmd == K_WRITE)); // R2

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == K_WRITE) |-> (sd_dq_oe && sd_dqm == '0)); // R3

  AST_MASK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_dq_oe) |-> (sd_dqm == {DM_W{1'b1}})); // R3

  AST_TERM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == K_BST) |-> (!sd_dq_oe && sd_dqm == {DM_W{1'b1}})); // R5

  AST_PRE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == K_PRE) |-> (!sd_dq_oe && sd_dqm == {DM_W{1'b1}})); // R6

  AST_TRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RP > 1 && sd_cmd == K_PRE) |->
      !(req_valid && req_ready && req_op != 2'd2 && req_bank == sd_ba)); // R7

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == K_READ) |-> !sd_dq_oe); // R9

endmodule

bind sdram_wseq sdram_wseq_chk #(
  .T_RP (T_RP),
  .BA_W (BA_W),
  .DM_W (DM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_bank  (req_bank),
  .sd_cmd    (sd_cmd),
  .sd_ba     (sd_ba),
  .sd_dq_oe  (sd_dq_oe),
  .sd_dqm    (sd_dqm)
);

// File: tb/sdram_wseq_bench.sv
`timescale 1ns/1ps
module sdram_wseq_bench;

  localparam int BL  = 4;
  localparam int CL  = 2;
  localparam int TRP = 3;
  localparam int CW  = 8;
  localparam int DW  = 16;
  localparam int NB  = 4;
  localparam int NCOL = 1 << CW;

  localparam logic [3:0] E_NOP = 4'b0111;
  localparam logic [3:0] E_RD  = 4'b0101;
  localparam logic [3:0] E_WR  = 4'b0100;
  localparam logic [3:0] E_BST = 4'b0110;
  localparam logic [3:0] E_PRE = 4'b0010;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [1:0]    req_bank;
  logic [CW-1:0] req_col;
  logic          req_ready;
  logic [DW-1:0] wr_data;
  logic [3:0]    sd_cmd;
  logic [1:0]    sd_ba;
  logic [CW-1:0] sd_addr;
  logic [DW-1:0] sd_dq_out;
  logic          sd_dq_oe;
  logic [1:0]    sd_dqm;
  logic [DW-1:0] sd_dq_in;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  sdram_wseq #(
    .BURST_LEN (BL), .CAS_LAT (CL), .T_RP (TRP),
    .COL_W (CW), .DQ_W (DW), .BANKS (NB)
  ) u_sdram_wseq (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_op (req_op), .req_bank (req_bank),
    .req_col (req_col), .req_ready (req_ready), .wr_data (wr_data),
    .sd_cmd (sd_cmd), .sd_ba (sd_ba), .sd_addr (sd_addr),
    .sd_dq_out (sd_dq_out), .sd_dq_oe (sd_dq_oe), .sd_dqm (sd_dqm),
    .sd_dq_in (sd_dq_in), .rd_valid (rd_valid), .rd_data (rd_data)
  );

  always #2 clk = ~clk;

  int total, bad, cyc;
  bit finished;

  logic [DW-1:0] exp_mem [NB][NCOL];
  logic [DW-1:0] dev_mem [NB][NCOL];
  int e_left, e_k;
  logic [1:0] e_bank;
  logic [CW-1:0] e_col;
  logic [3:0] x_cmd;
  logic [1:0] x_ba;
  logic [CW-1:0] x_addr;
  int pre_out [NB];
  int pre_seen [NB];
  int d_left, d_k;
  logic [1:0] d_bank;
  logic [CW-1:0] d_col;
  logic ring_v [16];
  logic [DW-1:0] ring_d [16];
  logic rv_v [32];
  logic [DW-1:0] rv_d [32];
  logic prev_oe;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Bus-side observation and memory model, once per cycle at the falling edge.
  task automatic observe();
    int s = cyc % 16;
    int r = cyc % 32;
    bit ok;
    if (ring_v[s]) begin
      sd_dq_in = ring_d[s];
      chk(!sd_dq_oe && !prev_oe, "R9 bus released around read data", {sd_dq_oe, prev_oe}, 0);
      ring_v[s] = 0;
    end else begin
      sd_dq_in = 16'hBEEF;
    end
    chk(sd_cmd == x_cmd, "R2 command", sd_cmd, x_cmd);
    if (x_cmd == E_WR || x_cmd == E_RD || x_cmd == E_PRE)
      chk(sd_ba == x_ba && sd_addr == x_addr, "R2 bank/column", {sd_ba, sd_addr}, {x_ba, x_addr});
    if (sd_cmd == E_WR || sd_cmd == E_RD || sd_cmd == E_PRE) begin
      chk(cyc - pre_seen[sd_ba] >= TRP, "R7 recovery spacing", cyc - pre_seen[sd_ba], TRP);
      if (sd_cmd == E_PRE) pre_seen[sd_ba] = cyc;
    end
    if (sd_cmd == E_BST) chk(!sd_dq_oe && sd_dqm == 2'b11, "R5 terminate clock masked", {sd_dq_oe, sd_dqm}, 3);
    if (sd_cmd == E_PRE) chk(!sd_dq_oe && sd_dqm == 2'b11, "R6 precharge clock masked", {sd_dq_oe, sd_dqm}, 3);
    if (sd_cmd == E_RD)  chk(!sd_dq_oe, "R9 read clock released", sd_dq_oe, 0);
    ok = (sd_dq_oe && sd_dqm == 2'b00) || (!sd_dq_oe && sd_dqm == 2'b11);
    chk(ok, "R3 DQM follows drive", {sd_dq_oe, sd_dqm}, 0);
    // memory model
    if (sd_cmd == E_WR) begin
      d_bank = sd_ba; d_col = sd_addr; d_left = BL; d_k = 0;
    end else if (sd_cmd == E_BST || sd_cmd == E_PRE || sd_cmd == E_RD) begin
      d_left = 0;
    end
    if (sd_cmd == E_RD) begin
      for (int k = 0; k < BL; k++) begin
        ring_v[(cyc + CL + k) % 16] = 1;
        ring_d[(cyc + CL + k) % 16] = dev_mem[sd_ba][CW'(sd_addr + k)];
      end
    end
    if (d_left > 0 && (sd_cmd == E_WR || sd_cmd == E_NOP)) begin
      if (sd_dq_oe && sd_dqm == 2'b00) dev_mem[d_bank][CW'(d_col + d_k)] = sd_dq_out;
      d_k++; d_left--;
    end
    if (rv_v[r] || rd_valid) begin
      chk(rd_valid == rv_v[r] && (!rd_valid || rd_data == rv_d[r]), "R8 read capture",
          {rd_valid, rd_data}, {rv_v[r], rv_d[r]});
      rv_v[r] = 0;
    end
    prev_oe = sd_dq_oe;
  endtask

  task automatic tick(input bit v, input logic [1:0] op, input logic [1:0] bank,
                      input logic [CW-1:0] col, output bit acc);
    @(negedge clk);
    cyc++;
    observe();
    req_valid = v; req_op = op; req_bank = bank; req_col = col;
    wr_data = DW'($urandom);
    #1;
    acc = v && req_ready;
    if (v && op != 2'd2 && (cyc + 1 - pre_out[bank]) < TRP)
      chk(!req_ready, "R7 ready low in recovery", req_ready, 0);
    x_cmd = E_NOP;
    if (acc) begin
      case (op)
        2'd0: begin
          x_cmd = E_WR; x_ba = bank; x_addr = col;
          exp_mem[bank][col] = wr_data;
          e_bank = bank; e_col = col; e_k = 1; e_left = BL - 1;
        end
        2'd1: begin
          x_cmd = E_RD; x_ba = bank; x_addr = col; e_left = 0;
          for (int k = 0; k < BL; k++) begin
            rv_v[(cyc + CL + 2 + k) % 32] = 1;
            rv_d[(cyc + CL + 2 + k) % 32] = exp_mem[bank][CW'(col + k)];
          end
        end
        2'd2: begin
          x_cmd = E_BST; e_left = 0;
        end
        default: begin
          x_cmd = E_PRE; x_ba = bank; x_addr = '0; e_left = 0;
          pre_out[bank] = cyc + 1;
        end
      endcase
    end else if (e_left > 0) begin
      exp_mem[e_bank][CW'(e_col + e_k)] = wr_data;
      e_k++; e_left--;
    end
  endtask

  task automatic idle(input int n);
    bit a;
    repeat (n) tick(0, 2'd0, 2'd0, '0, a);
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] bank,
                      input logic [CW-1:0] col, output int stalls);
    bit a;
    stalls = 0;
    tick(1, op, bank, col, a);
    while (!a && stalls < 100) begin
      stalls++;
      tick(1, op, bank, col, a);
    end
  endtask

  task automatic cmp_range(input logic [1:0] bank, input logic [CW-1:0] col, input string req);
    int miss = 0;
    for (int k = 0; k < BL; k++)
      if (dev_mem[bank][CW'(col + k)] !== exp_mem[bank][CW'(col + k)]) miss++;
    chk(miss == 0, req, miss, 0);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    int st;
    int miss;
    bit a;
    bit hold;
    logic [1:0] h_op, h_bank;
    logic [CW-1:0] h_col;
    int pick;
    void'($urandom(32'h5D2A91));
    clk = 0; rst_n = 0; total = 0; bad = 0; cyc = 0; finished = 0;
    req_valid = 0; req_op = 0; req_bank = 0; req_col = 0; wr_data = 0; sd_dq_in = 0;
    for (int b = 0; b < NB; b++) begin
      pre_out[b] = -100; pre_seen[b] = -100;
      for (int c = 0; c < NCOL; c++) begin exp_mem[b][c] = '0; dev_mem[b][c] = '0; end
    end
    for (int i = 0; i < 16; i++) ring_v[i] = 0;
    for (int i = 0; i < 32; i++) rv_v[i] = 0;
    e_left = 0; e_k = 0; d_left = 0; d_k = 0; prev_oe = 0; x_cmd = E_NOP;
    e_bank = 0; e_col = 0; d_bank = 0; d_col = 0; x_ba = 0; x_addr = 0;

    // R1: reset state
    req_valid = 1;
    repeat (3) @(negedge clk);
    chk(sd_cmd == E_NOP, "R1 reset command", sd_cmd, E_NOP);
    chk(!sd_dq_oe && sd_dqm == 2'b11, "R1 reset DQ/DQM", {sd_dq_oe, sd_dqm}, 3);
    chk(!rd_valid, "R1 reset rd_valid", rd_valid, 0);
    chk(!req_ready, "R1 reset ready", req_ready, 0);
    req_valid = 0;
    rst_n = 1;
    idle(4);

    // R3: full burst
    send(2'd0, 2'd0, 8'd16, st);
    chk(st == 0, "R1 ready after reset", st, 0);
    idle(6);
    cmp_range(2'd0, 8'd16, "R3 full burst stored");

    // R4: interrupting write to another bank
    send(2'd0, 2'd1, 8'd32, st); idle(1);
    send(2'd0, 2'd2, 8'd48, st); idle(6);
    cmp_range(2'd1, 8'd32, "R4 interrupted burst");
    cmp_range(2'd2, 8'd48, "R4 interrupting burst");

    // R5: terminate
    send(2'd0, 2'd3, 8'd64, st); idle(1);
    send(2'd2, 2'd0, 8'd0, st); idle(4);
    cmp_range(2'd3, 8'd64, "R5 terminated burst");

    // R6 / R7: precharge truncation and recovery
    send(2'd0, 2'd0, 8'd80, st); idle(1);
    send(2'd3, 2'd0, 8'd0, st);
    send(2'd0, 2'd0, 8'd96, st);
    chk(st == TRP - 1, "R7 same-bank stall", st, TRP - 1);
    send(2'd3, 2'd2, 8'd0, st);
    send(2'd0, 2'd1, 8'd104, st);
    chk(st == 0, "R7 other bank not held", st, 0);
    idle(6);
    cmp_range(2'd0, 8'd80, "R6 precharge-truncated burst");

    // R8: read in the clock after a write
    send(2'd0, 2'd1, 8'd0, st);
    send(2'd1, 2'd1, 8'd0, st);
    chk(st == 0, "R8 read right after write", st, 0);
    idle(10);

    // R9: write held off until read data has passed
    send(2'd1, 2'd2, 8'd48, st);
    send(2'd0, 2'd2, 8'd120, st);
    chk(st == CL + BL, "R9 write stall after read", st, CL + BL);
    idle(8);

    // Random mix
    hold = 0; h_op = 0; h_bank = 0; h_col = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!hold) begin
        pick = $urandom_range(99);
        h_bank = 2'($urandom_range(3));
        h_col = CW'($urandom);
        if (pick < 40) h_op = 2'd0;
        else if (pick < 52) h_op = 2'd1;
        else if (pick < 62) h_op = 2'd2;
        else if (pick < 72) h_op = 2'd3;
        hold = (pick < 72);
      end
      tick(hold, h_op, h_bank, h_col, a);
      if (a) hold = 0;
    end
    tick(0, 2'd0, 2'd0, '0, a);
    idle(12);

    miss = 0;
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < NCOL; c++)
        if (dev_mem[b][c] !== exp_mem[b][c]) miss++;
    chk(miss == 0, "R3 final memory contents", miss, 0);
    summary();
  end

endmodule